// File: doc/BRIEF.md
# Slot-Based Power Rail Sequencer

This block sets the order in which a board's power rail enables turn on and off. Every enable output and every rail monitor channel carries a slot number. When both the pin enable and the software enable are high, the sequencer starts at slot 0 and steps upward. On entering a slot it drives the enables that belong to that slot. It then waits until every rail watched in that slot reports good, and only then times that slot's delay. If a slot's rails stay low longer than the selected fault timeout, the sequencer drops all enables and latches a fault. After the last slot it runs a reset timeout and then releases the active-low reset.

When either enable goes low, power-down starts. In reverse mode the enables go off one slot at a time, from the highest slot down to slot 1, with each slot's delay between steps. Otherwise every enable goes off at once. All timing is counted in microseconds derived from a clock-cycles-per-microsecond parameter. Undervoltage detection happens upstream: the block receives one good/bad flag per rail.

Top module: `rail_sequencer`

## Requirements
- R1: Sequencing starts only while `hw_en_i` and `sw_en_i` are both 1. It begins at slot 0, which owns no enables. With only one of the two high, all enables stay 0 and `state_o` stays 0.
- R2: Slot codes are packed 3 bits per channel, with channel i at bits [3i+2:3i]. Code 0 means the channel is not sequenced. On entering slot s, every enable with code s goes high, and enables of earlier slots stay high.
- R3: A slot's delay of D µs (field k of `slot_dly_i`, bits [17k+16:17k]) starts only once every monitor coded with the current slot reports `uv_ok_i` high. Monitor code 0 means the channel is not watched. The next slot is entered D·CLK_PER_US to D·CLK_PER_US+4 cycles after the rails are good.
- R4: If a slot's rails are not all good within the fault timeout, counted from entry to the slot, `fault_o` goes high and all enables go low.
- R5: `flt_code_i` values 0 to 15 select 120, 150, 250, 380, 600, 1000, 1500, 2500, 4000, 6000, 10000, 15000, 25000, 40000, 60000 and 100000 µs.
- R6: After the last slot's rails are good and its delay ends, `rst_dly_i` µs are counted, and then `rst_no` goes high.
- R7: Power-down starts when either `hw_en_i` or `sw_en_i` goes low.
- R8: With `rev_dn_i`=1, power-down first clears the enables of the current slot and above. After each slot's delay it clears the next lower slot, down to slot 1.
- R9: With `rev_dn_i`=0, all enables go low on the cycle after power-down starts.
- R10: The fault state holds while both enables stay high. Dropping either enable clears `fault_o`, and a later start begins again from slot 0.
- R11: `rst_no` is 0 in every state other than fully on, including fault and power-down.
- R12: `state_o` encoding: 0 idle, 1 waiting for rails, 2 slot delay, 3 reset timeout, 4 on, 5 reverse power-down, 6 fault.
- R13: While `rst_ni` is low, all enables, `rst_no` and `fault_o` are 0, and `state_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_en_i | input | 1 | Pin enable |
| sw_en_i | input | 1 | Software enable bit |
| rev_dn_i | input | 1 | 1: reverse-order power-down, 0: all at once |
| uv_ok_i | input | N_MON | Per-rail above-undervoltage flag |
| en_slot_i | input | N_EN*SW | Slot code per enable output |
| mon_slot_i | input | N_MON*SW | Slot code per monitor channel |
| slot_dly_i | input | N_SLOT*TW | Per-slot delay in µs |
| flt_code_i | input | 4 | Fault timeout select |
| rst_dly_i | input | TW | Reset timeout in µs |
| en_o | output | N_EN | Rail enables |
| rst_no | output | 1 | Active-low system reset |
| fault_o | output | 1 | Sequencing fault |
| state_o | output | 3 | Current state |
| slot_o | output | SW | Current slot |

## Verification
On every cycle, the assertions check how the state and slot are allowed to move. The slot rises by exactly one on each upward step and falls by one in reverse power-down. The slot delay is entered only when the rails were good. Fault is entered only from the rail wait after the timeout has run out. Reset is released only from the reset timeout. The bench scenarios are needed for the behaviours that depend on elapsed time: the exact slot delays, the fault timeout table, the reset timeout, and the stall while a rail stays bad. The same holds for the full power-down order and for restart after a fault.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_DLY  = 3'd2,
    ST_RST  = 3'd3,
    ST_ON   = 3'd4,
    ST_DN   = 3'd5,
    ST_FLT  = 3'd6
  } seq_st_e;

  typedef enum logic [1:0] {
    EM_OFF = 2'd0,
    EM_UP  = 2'd1,
    EM_DN  = 2'd2
  } en_mode_e;

  // fault timeout in microseconds
  function automatic logic [16:0] flt_us(input logic [3:0] code);
    case (code)
      4'd0:    flt_us = 17'd120;
      4'd1:    flt_us = 17'd150;
      4'd2:    flt_us = 17'd250;
      4'd3:    flt_us = 17'd380;
      4'd4:    flt_us = 17'd600;
      4'd5:    flt_us = 17'd1000;
      4'd6:    flt_us = 17'd1500;
      4'd7:    flt_us = 17'd2500;
      4'd8:    flt_us = 17'd4000;
      4'd9:    flt_us = 17'd6000;
      4'd10:   flt_us = 17'd10000;
      4'd11:   flt_us = 17'd15000;
      4'd12:   flt_us = 17'd25000;
      4'd13:   flt_us = 17'd40000;
      4'd14:   flt_us = 17'd60000;
      default: flt_us = 17'd100000;
    endcase
  endfunction

endpackage

// File: rtl/us_timer.sv
module us_timer #(
  parameter int CLK_PER_US = 25,
  parameter int TW         = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          busy_o
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] PRE_MAX = PW'(CLK_PER_US - 1);

  logic [PW-1:0] pre_q;
  logic [TW-1:0] us_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      us_q   <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      pre_q  <= PRE_MAX;
      us_q   <= val_i;
      busy_q <= (val_i != '0);
    end else if (busy_q) begin
      if (pre_q == '0) begin
        pre_q <= PRE_MAX;
        us_q  <= us_q - 1'b1;
        if (us_q == TW'(1)) busy_q <= 1'b0;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;

  // R3: microsecond count only holds or steps down by one
  p_tmr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !load_i) |=> ((us_q == $past(us_q)) || (us_q == $past(us_q) - 1'b1)));

endmodule

// File: rtl/slot_decode.sv
module slot_decode
  import rail_seq_pkg::*;
#(
  parameter int N_EN  = 6,
  parameter int N_MON = 6,
  parameter int SW    = 3
) (
  input  logic [SW-1:0]       slot_i,
  input  en_mode_e            mode_i,
  input  logic [N_EN*SW-1:0]  en_slot_i,
  input  logic [N_MON*SW-1:0] mon_slot_i,
  input  logic [N_MON-1:0]    uv_ok_i,
  output logic [N_EN-1:0]     en_o,
  output logic                rails_ok_o
);
  logic [N_MON-1:0] mon_ok;

  for (genvar i = 0; i < N_EN; i++) begin : g_en
    logic [SW-1:0] code;
    assign code = en_slot_i[i*SW +: SW];
    always_comb begin
      case (mode_i)
        EM_UP:   en_o[i] = (code != '0) && (code <= slot_i);
        EM_DN:   en_o[i] = (code != '0) && (code <  slot_i);
        default: en_o[i] = 1'b0;
      endcase
    end
  end

  for (genvar m = 0; m < N_MON; m++) begin : g_mon
    logic [SW-1:0] code;
    assign code      = mon_slot_i[m*SW +: SW];
    assign mon_ok[m] = uv_ok_i[m] || (code == '0) || (code != slot_i);
  end

  assign rails_ok_o = &mon_ok;

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rail_seq_pkg::*;
#(
  parameter int N_EN       = 6,
  parameter int N_MON      = 6,
  parameter int N_SLOT     = 7,
  parameter int CLK_PER_US = 25,
  parameter int TW         = 17,
  localparam int SW        = $clog2(N_SLOT)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hw_en_i,
  input  logic                 sw_en_i,
  input  logic                 rev_dn_i,
  input  logic [N_MON-1:0]     uv_ok_i,
  input  logic [N_EN*SW-1:0]   en_slot_i,
  input  logic [N_MON*SW-1:0]  mon_slot_i,
  input  logic [N_SLOT*TW-1:0] slot_dly_i,
  input  logic [3:0]           flt_code_i,
  input  logic [TW-1:0]        rst_dly_i,
  output logic [N_EN-1:0]      en_o,
  output logic                 rst_no,
  output logic                 fault_o,
  output logic [2:0]           state_o,
  output logic [SW-1:0]        slot_o
);
  localparam int NSEL = 2 ** SW;
  localparam logic [SW-1:0] LAST = SW'(N_SLOT - 1);

  seq_st_e       st_q, st_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          stg_load, flt_load, stg_busy, flt_busy, rails_ok, go;
  logic [TW-1:0] stg_val;
  en_mode_e      mode;
  logic [TW-1:0] dly_a [NSEL];

  for (genvar k = 0; k < NSEL; k++) begin : g_dly
    if (k < N_SLOT) begin : g_used
      assign dly_a[k] = slot_dly_i[k*TW +: TW];
    end else begin : g_pad
      assign dly_a[k] = '0;
    end
  end

  assign go = hw_en_i && sw_en_i;

  always_comb begin
    st_d     = st_q;
    slot_d   = slot_q;
    stg_load = 1'b0;
    stg_val  = dly_a[slot_q];
    flt_load = 1'b0;
    unique case (st_q)
      ST_IDLE: if (go) begin
        st_d     = ST_WAIT;
        slot_d   = '0;
        flt_load = 1'b1;
      end
      ST_FLT: if (!go) st_d = ST_IDLE;
      ST_DN: if (!stg_busy) begin
        if (slot_q <= SW'(1)) begin
          st_d   = ST_IDLE;
          slot_d = '0;
        end else begin
          slot_d   = slot_q - 1'b1;
          stg_load = 1'b1;
          stg_val  = dly_a[slot_q - 1'b1];
        end
      end
      default: begin
        if (!go) begin
          if (rev_dn_i && slot_q != '0) begin
            st_d     = ST_DN;
            stg_load = 1'b1;
          end else begin
            st_d   = ST_IDLE;
            slot_d = '0;
          end
        end else if (st_q == ST_WAIT) begin
          if (rails_ok) begin
            st_d     = ST_DLY;
            stg_load = 1'b1;
          end else if (!flt_busy) begin
            st_d = ST_FLT;
          end
        end else if (st_q == ST_DLY) begin
          if (!stg_busy) begin
            if (slot_q == LAST) begin
              st_d     = ST_RST;
              stg_load = 1'b1;
              stg_val  = rst_dly_i;
            end else begin
              st_d     = ST_WAIT;
              slot_d   = slot_q + 1'b1;
              flt_load = 1'b1;
            end
          end
        end else if (st_q == ST_RST) begin
          if (!stg_busy) st_d = ST_ON;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_WAIT, ST_DLY, ST_RST, ST_ON: mode = EM_UP;
      ST_DN:                          mode = EM_DN;
      default:                        mode = EM_OFF;
    endcase
  end

  us_timer #(.CLK_PER_US(CLK_PER_US), .TW(TW)) u_stage_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(stg_load),
    .val_i (stg_val),
    .busy_o(stg_busy)
  );

  us_timer #(.CLK_PER_US(CLK_PER_US), .TW(TW)) u_flt_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(flt_load),
    .val_i (TW'(flt_us(flt_code_i))),
    .busy_o(flt_busy)
  );

  slot_decode #(.N_EN(N_EN), .N_MON(N_MON), .SW(SW)) u_dec (
    .slot_i    (slot_q),
    .mode_i    (mode),
    .en_slot_i (en_slot_i),
    .mon_slot_i(mon_slot_i),
    .uv_ok_i   (uv_ok_i),
    .en_o      (en_o),
    .rails_ok_o(rails_ok)
  );

  assign rst_no  = (st_q == ST_ON);
  assign fault_o = (st_q == ST_FLT);
  assign state_o = st_q;
  assign slot_o  = slot_q;

  p_start_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !(hw_en_i && sw_en_i)) |=> (st_q == ST_IDLE));

  p_slot_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && $past(st_q) == ST_DLY) |-> (slot_q == $past(slot_q) + 1'b1));

  p_dly_after_good_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DLY && $past(st_q) == ST_WAIT) |-> $past(rails_ok));

  p_fault_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> ($past(st_q) == ST_WAIT && !$past(flt_busy) && !$past(rails_ok)));

  p_rst_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> ($past(st_q) == ST_RST && !$past(stg_busy)));

  p_dn_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DN && $past(st_q) == ST_DN && slot_q != $past(slot_q))
      |-> (slot_q == $past(slot_q) - 1'b1));

endmodule

// File: tb/rail_sequencer_test.sv
module rail_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int P      = 4;
  localparam int N_EN   = 6;
  localparam int N_MON  = 6;
  localparam int N_SLOT = 7;
  localparam int TW     = 17;
  localparam int SW     = 3;
  localparam int RDLY   = 20;
  localparam int WD_MAX = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hw_en = 1'b0, sw_en = 1'b0, rev_dn = 1'b1;
  logic [N_MON-1:0] uv_ok = '1;
  logic [N_EN*SW-1:0] en_slot;
  logic [N_MON*SW-1:0] mon_slot;
  logic [N_SLOT*TW-1:0] slot_dly;
  logic [3:0] flt_code = 4'd0;
  logic [TW-1:0] rst_dly = TW'(RDLY);
  logic [N_EN-1:0] en_o;
  logic rst_no, fault_o;
  logic [2:0] state_o;
  logic [SW-1:0] slot_o;

  rail_sequencer #(.N_EN(N_EN), .N_MON(N_MON), .N_SLOT(N_SLOT), .CLK_PER_US(P), .TW(TW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .hw_en_i(hw_en), .sw_en_i(sw_en), .rev_dn_i(rev_dn),
    .uv_ok_i(uv_ok), .en_slot_i(en_slot), .mon_slot_i(mon_slot), .slot_dly_i(slot_dly),
    .flt_code_i(flt_code), .rst_dly_i(rst_dly), .en_o(en_o), .rst_no(rst_no),
    .fault_o(fault_o), .state_o(state_o), .slot_o(slot_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, checks = 0, errors = 0, t_ref = 0;
  bit mon_on = 0;
  logic [7:0] last_obs;
  logic [7:0] q_obs[$];
  int q_lo[$], q_hi[$];
  string q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int dly(int k);
    return k + 2;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(logic [5:0] en, logic rn, logic fl, int lo, int hi, string tag);
    q_obs.push_back({en, rn, fl});
    q_lo.push_back(lo);
    q_hi.push_back(hi);
    q_tag.push_back(tag);
  endtask

  // monitor: pop one expected item per output change
  always @(negedge clk) begin
    if (mon_on) begin
      logic [7:0] obs;
      obs = {en_o, rst_no, fault_o};
      if (obs !== last_obs) begin
        int el;
        el = cyc - t_ref;
        t_ref = cyc;
        if (q_obs.size() == 0) begin
          chk(0, "SB", "unexpected output change", int'(obs), int'(last_obs));
        end else begin
          logic [7:0] e;
          int lo, hi;
          string tg;
          e = q_obs.pop_front();
          lo = q_lo.pop_front();
          hi = q_hi.pop_front();
          tg = q_tag.pop_front();
          chk(obs === e, tg, "outputs", int'(obs), int'(e));
          chk(el >= lo && el <= hi, tg, "elapsed cycles", el, lo);
        end
        last_obs = obs;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WD_MAX) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_MAX);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drv_go(logic h, logic s);
    @(negedge clk);
    #1;
    hw_en = h;
    sw_en = s;
    t_ref = cyc;
  endtask

  task automatic wait_q();
    while (q_obs.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic push_slot(int k, int lo, int hi, string tag);
    push(6'((1 << k) - 1), 1'b0, 1'b0, lo, hi, tag);
  endtask

  // R2 R3 R6: full upward walk from go
  task automatic push_up_from(int k0);
    for (int k = k0; k <= 6; k++) begin
      if (k == 1) push_slot(1, dly(0)*P, dly(0)*P + 6, "R2_slot1");
      else        push_slot(k, dly(k-1)*P, dly(k-1)*P + 4, "R3_slot_delay");
    end
    push(6'h3f, 1'b1, 1'b0, (dly(6) + RDLY)*P, (dly(6) + RDLY)*P + 6, "R6_reset_release");
  endtask

  initial begin
    for (int i = 0; i < N_EN; i++)   en_slot[i*SW +: SW]  = SW'(i + 1);
    for (int i = 0; i < N_MON; i++)  mon_slot[i*SW +: SW] = SW'(i + 1);
    for (int k = 0; k < N_SLOT; k++) slot_dly[k*TW +: TW] = TW'(dly(k));

    repeat (3) @(negedge clk);
    chk(en_o == '0 && rst_no == 0 && fault_o == 0, "R13", "outputs in reset",
        int'({en_o, rst_no, fault_o}), 0);
    chk(state_o == 3'd0, "R13", "state in reset", int'(state_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    last_obs = {en_o, rst_no, fault_o};
    mon_on = 1;

    // R1: one enable alone does nothing
    drv_go(1'b1, 1'b0);
    repeat (200) @(negedge clk);
    chk(en_o == '0 && state_o == 3'd0, "R1", "hw only", int'({state_o, en_o}), 0);
    drv_go(1'b0, 1'b1);
    repeat (200) @(negedge clk);
    chk(en_o == '0 && state_o == 3'd0, "R1", "sw only", int'({state_o, en_o}), 0);

    // power-up, then reverse power-down
    push_up_from(1);
    drv_go(1'b1, 1'b1);
    wait_q();
    chk(state_o == 3'd4, "R12", "state on", int'(state_o), 4);
    chk(rst_no == 1'b1, "R6", "reset released", int'(rst_no), 1);
    push(6'h1f, 1'b0, 1'b0, 0, 3, "R7_R11_dn_start");
    for (int c = 5; c >= 1; c--)
      push_slot(c - 1, dly(c+1)*P, dly(c+1)*P + 4, "R8_reverse_step");
    drv_go(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    chk(state_o == 3'd5, "R12", "state reverse down", int'(state_o), 5);
    wait_q();
    repeat (30) @(negedge clk);
    chk(state_o == 3'd0, "R8", "idle after reverse", int'(state_o), 0);

    // simultaneous power-down via hw pin
    rev_dn = 1'b0;
    push_up_from(1);
    drv_go(1'b1, 1'b1);
    wait_q();
    push(6'h00, 1'b0, 1'b0, 0, 3, "R9_all_off");
    drv_go(1'b0, 1'b1);
    wait_q();
    chk(state_o == 3'd0, "R9", "idle after all off", int'(state_o), 0);

    // R3: slot 2 rail stalls
    uv_ok[1] = 1'b0;
    push_up_from(1);
    drv_go(1'b1, 1'b1);
    while (q_obs.size() > 6) @(negedge clk);
    repeat (100) @(negedge clk);
    chk(en_o == 6'h03 && state_o == 3'd1, "R3", "stalled in slot 2", int'({state_o, en_o}), 'h43);
    @(negedge clk);
    #1;
    uv_ok[1] = 1'b1;
    t_ref = cyc;
    wait_q();
    push(6'h00, 1'b0, 1'b0, 0, 3, "R9_all_off");
    drv_go(1'b1, 1'b0);
    wait_q();

    // R4 R5: fault with code 0
    uv_ok[2] = 1'b0;
    flt_code = 4'd0;
    push_slot(1, dly(0)*P, dly(0)*P + 6, "R2_slot1");
    push_slot(2, dly(1)*P, dly(1)*P + 4, "R3_slot_delay");
    push_slot(3, dly(2)*P, dly(2)*P + 4, "R3_slot_delay");
    push(6'h00, 1'b0, 1'b1, 120*P, 120*P + 4, "R4_R5_fault_code0");
    drv_go(1'b1, 1'b1);
    wait_q();
    chk(state_o == 3'd6 && fault_o, "R12", "state fault", int'(state_o), 6);
    repeat (100) @(negedge clk);
    chk(state_o == 3'd6 && rst_no == 0, "R10_R11", "fault held", int'({state_o, rst_no}), 12);
    push(6'h00, 1'b0, 1'b0, 0, 3, "R10_fault_clear");
    drv_go(1'b0, 1'b1);
    wait_q();

    // R5: code 1
    flt_code = 4'd1;
    push_slot(1, dly(0)*P, dly(0)*P + 6, "R10_restart_slot1");
    push_slot(2, dly(1)*P, dly(1)*P + 4, "R3_slot_delay");
    push_slot(3, dly(2)*P, dly(2)*P + 4, "R3_slot_delay");
    push(6'h00, 1'b0, 1'b1, 150*P, 150*P + 4, "R5_fault_code1");
    drv_go(1'b1, 1'b1);
    wait_q();

    // R10: clear and restart cleanly from slot 0
    push(6'h00, 1'b0, 1'b0, 0, 3, "R10_fault_clear");
    drv_go(1'b1, 1'b0);
    wait_q();
    uv_ok = '1;
    push_up_from(1);
    drv_go(1'b1, 1'b1);
    wait_q();
    chk(state_o == 3'd4 && slot_o == 3'd6, "R10", "full restart", int'({state_o, slot_o}), 'h26);

    chk(q_obs.size() == 0, "SB", "queue drained", q_obs.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule